// File: doc/BRIEF.md
# Parallel Sensor Byte Capture

This block takes an 8-bit parallel stream that an external device drives on its own clock. Typical sources are an image sensor, a fast converter or a synchronous serial-to-parallel port. On each rising edge of the sensor clock the block decides whether to take the byte. The decision depends on two qualifier lines, which can be honoured or bypassed, and on an optional one-in-two decimator whose kept phase is selectable. Accepted bytes are packed into a word of 8, 16 or 32 bits. The first byte accepted lands in the least significant byte. Each finished word crosses into the system clock domain through a small asynchronous FIFO, and the system side presents it on a valid/ready output stream.

Configuration is a set of plain system-domain levels. The capture enable is synchronized into the sensor domain. The other mode levels may change only while capture is disabled. Dropping the enable clears the packer position and the decimation phase, so the next capture starts on a word boundary. The sensor pins are inputs only.

The output stream follows these rules. `word_valid` rises once a word is available. `word_data` holds steady until a rising `clk` edge sees both `word_valid` and `word_ready`. A handshake and the load of the next buffered word may fall in the same cycle, which gives one word per cycle when the consumer keeps `word_ready` high. While the consumer stalls, words queue up to the FIFO depth plus the holding register. A word that finishes with no room left is dropped, and `overrun` is raised.

Top module: `par_capture`

## Requirements
- R1: After reset, `word_valid` and `overrun` are 0 and `word_data` is 0.
- R2: With `cfg_ignore_de`=0, a byte is accepted on a rising `sen_clk` edge only when `sen_de_a` and `sen_de_b` are both 1; otherwise the packer position and decimation phase do not move.
- R3: With `cfg_ignore_de`=1, a byte is accepted on every rising `sen_clk` edge, whatever the qualifier lines carry.
- R4: With `cfg_decimate`=1, only one of each pair of accepted bytes is kept. `cfg_keep_second`=0 keeps the 1st, 3rd and so on; `cfg_keep_second`=1 keeps the 2nd, 4th and so on.
- R5: `cfg_size` encodes 0 as 8 bits, 1 as 16 bits, and 2 or 3 as 32 bits. Kept bytes fill the word from bit 7:0 upward, unused upper bits read 0, and a word is delivered only when it is full.
- R6: While `word_valid`=1 and `word_ready`=0, `word_valid` stays 1 and `word_data` does not change.
- R7: While the consumer stalls, up to FIFO depth (4) plus one words are kept in arrival order. With `word_ready` held at 1 they are delivered one per `clk` cycle.
- R8: A word that completes when all buffering is occupied is discarded, and `overrun` becomes 1. `overrun` stays 1 until the next output handshake, which clears it.
- R9: Dropping `cfg_enable` resets the packer position and the decimation phase, so that bytes from a partial word or a half pair are not combined with later capture.
- R10: While `cfg_enable`=0, no byte is accepted and no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cfg_enable | input | 1 | Capture enable (system domain, synchronized) |
| cfg_size | input | 2 | Word size: 0 = 8, 1 = 16, 2/3 = 32 bits |
| cfg_ignore_de | input | 1 | 1 = accept bytes regardless of qualifiers |
| cfg_decimate | input | 1 | 1 = keep one of each pair of accepted bytes |
| cfg_keep_second | input | 1 | Decimation phase: 0 = first of pair, 1 = second |
| sen_clk | input | 1 | Sensor clock, unrelated to `clk` |
| sen_data | input | 8 | Sensor byte, sampled on rising `sen_clk` |
| sen_de_a | input | 1 | First data qualifier |
| sen_de_b | input | 1 | Second data qualifier |
| word_valid | output | 1 | A packed word is presented |
| word_ready | input | 1 | Consumer accepts the presented word |
| word_data | output | 32 | Packed word, first byte in bits 7:0 |
| overrun | output | 1 | Sticky drop indicator, cleared by a handshake |

## Verification
Two events can coincide in one `clk` cycle: the consumer takes the presented word, and the holding register reloads from the FIFO. To provoke this, the bench stalls `word_ready` while six single-byte words arrive. Four of them fill the FIFO, one sits in the holding register and the sixth is dropped. The bench then raises `word_ready` and keeps it high. It judges the result on the following cycles: `word_valid` must stay 1, the five words must appear in order one per cycle, `overrun` must fall after the first handshake, and `word_valid` must drop after the fifth word.

// File: rtl/par_capture_pkg.sv
package par_capture_pkg;

  // Index of the last byte lane used for a given size code, capped at the
  // number of lanes the word has.
  function automatic int last_lane(input logic [1:0] size_code, input int lanes);
    int n;
    n = 1 << size_code;
    if (n > lanes) n = lanes;
    return n - 1;
  endfunction

  function automatic logic [7:0] to_gray8(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/par_capture_sync.sv
module par_capture_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/par_capture_pack.sv
module par_capture_pack
  import par_capture_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = LANES * BYTE_W,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              sen_clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic [BYTE_W-1:0] sen_data,
  input  logic              de_a,
  input  logic              de_b,
  input  logic              ignore_de,
  input  logic              decimate,
  input  logic              keep_second,
  input  logic [1:0]        size_code,
  input  logic              full_i,
  output logic              push_o,
  output logic [DW-1:0]     push_data_o,
  output logic              lost_tgl_o
);
  logic [IW-1:0] idx_q;
  logic          phase_q;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] merged;
  logic [IW-1:0] last_idx;
  logic          qualify, keep, at_last;

  assign qualify  = en_s && (ignore_de || (de_a && de_b));
  assign keep     = qualify && (!decimate || (phase_q == keep_second));
  assign last_idx = IW'(last_lane(size_code, LANES));
  assign at_last  = (idx_q == last_idx);

  always_comb begin
    merged = acc_q;
    merged[int'(idx_q)*BYTE_W +: BYTE_W] = sen_data;
  end

  assign push_o      = keep && at_last && !full_i;
  assign push_data_o = merged;

  always_ff @(posedge sen_clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      phase_q    <= 1'b0;
      acc_q      <= '0;
      lost_tgl_o <= 1'b0;
    end else if (!en_s) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else begin
      if (qualify && decimate) phase_q <= ~phase_q;
      if (keep) begin
        if (at_last) begin
          idx_q <= '0;
          acc_q <= '0;
          if (full_i) lost_tgl_o <= ~lost_tgl_o;
        end else begin
          idx_q <= idx_q + 1'b1;
          acc_q <= merged;
        end
      end
    end
  end

  // Unqualified edges leave the packer untouched.
  assert_de_gate_R2: assert property (@(posedge sen_clk) disable iff (!rst_n)
    (en_s && !ignore_de && !(de_a && de_b)) |=> ($stable(idx_q) && $stable(phase_q)));

  // Disabled capture parks the packer on a word boundary.
  assert_disable_park_R9: assert property (@(posedge sen_clk) disable iff (!rst_n)
    !en_s |=> (idx_q == '0 && !phase_q));

  assert_no_push_off_R10: assert property (@(posedge sen_clk) disable iff (!rst_n)
    !en_s |-> !push_o);

  assert_idx_range_R5: assert property (@(posedge sen_clk) disable iff (!rst_n)
    en_s |-> (idx_q <= last_idx));
endmodule

// File: rtl/par_capture_afifo.sv
module par_capture_afifo
  import par_capture_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter int STAGES = 2,
  localparam int DEPTH = 1 << AW,
  localparam int PW    = AW + 1
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] wgray_rs, rgray_ws;
  logic [PW-1:0] wbin_nx, rbin_nx;

  assign wbin_nx = wbin_q + 1'b1;
  assign rbin_nx = rbin_q + 1'b1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_nx;
      wgray_q <= PW'(to_gray8(8'(wbin_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nx;
      rgray_q <= PW'(to_gray8(8'(rbin_nx)));
    end
  end

  par_capture_sync #(.W(PW), .STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray_q), .q(wgray_rs));

  par_capture_sync #(.W(PW), .STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray_q), .q(rgray_ws));

  assign full  = (wgray_q == {~rgray_ws[PW-1:PW-2], rgray_ws[PW-3:0]});
  assign empty = (rgray_q == wgray_rs);
  assign rdata = mem[rbin_q[AW-1:0]];

  assert_push_room_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    push |-> !full);

  assert_pop_data_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/par_capture_out.sv
module par_capture_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  input  logic          lost_tgl_s,
  output logic          word_valid,
  input  logic          word_ready,
  output logic [DW-1:0] word_data,
  output logic          overrun
);
  logic lost_prev_q;
  logic lost_evt;
  logic handshake;

  assign handshake = word_valid && word_ready;
  assign fifo_pop  = !fifo_empty && (!word_valid || word_ready);
  assign lost_evt  = lost_tgl_s ^ lost_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid  <= 1'b0;
      word_data   <= '0;
      overrun     <= 1'b0;
      lost_prev_q <= 1'b0;
    end else begin
      lost_prev_q <= lost_tgl_s;
      if (fifo_pop) begin
        word_valid <= 1'b1;
        word_data  <= fifo_data;
      end else if (handshake) begin
        word_valid <= 1'b0;
      end
      if (lost_evt)       overrun <= 1'b1;
      else if (handshake) overrun <= 1'b0;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !handshake) |=> overrun);

  assert_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !fifo_empty) |=> word_valid);
endmodule

// File: rtl/par_capture.sv
module par_capture #(
  parameter int LANES       = 4,
  parameter int BYTE_W      = 8,
  parameter int FIFO_AW     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DW         = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_ignore_de,
  input  logic              cfg_decimate,
  input  logic              cfg_keep_second,
  input  logic              sen_clk,
  input  logic [BYTE_W-1:0] sen_data,
  input  logic              sen_de_a,
  input  logic              sen_de_b,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [DW-1:0]     word_data,
  output logic              overrun
);
  logic          en_s;
  logic          push, full, pop, empty;
  logic [DW-1:0] push_data, pop_data;
  logic          lost_tgl, lost_tgl_s;

  par_capture_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk(sen_clk), .rst_n(rst_n), .d(cfg_enable), .q(en_s));

  par_capture_pack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_pack (
    .sen_clk    (sen_clk),
    .rst_n      (rst_n),
    .en_s       (en_s),
    .sen_data   (sen_data),
    .de_a       (sen_de_a),
    .de_b       (sen_de_b),
    .ignore_de  (cfg_ignore_de),
    .decimate   (cfg_decimate),
    .keep_second(cfg_keep_second),
    .size_code  (cfg_size),
    .full_i     (full),
    .push_o     (push),
    .push_data_o(push_data),
    .lost_tgl_o (lost_tgl)
  );

  par_capture_afifo #(.DW(DW), .AW(FIFO_AW), .STAGES(SYNC_STAGES)) u_fifo (
    .rst_n(rst_n),
    .wclk (sen_clk),
    .push (push),
    .wdata(push_data),
    .full (full),
    .rclk (clk),
    .pop  (pop),
    .rdata(pop_data),
    .empty(empty)
  );

  par_capture_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lost_sync (
    .clk(clk), .rst_n(rst_n), .d(lost_tgl), .q(lost_tgl_s));

  par_capture_out #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_empty(empty),
    .fifo_data (pop_data),
    .fifo_pop  (pop),
    .lost_tgl_s(lost_tgl_s),
    .word_valid(word_valid),
    .word_ready(word_ready),
    .word_data (word_data),
    .overrun   (overrun)
  );
endmodule

// File: tb/par_capture_bench.sv
`timescale 1ns/1ps
module par_capture_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_enable = 0;
  logic [1:0]  cfg_size = 0;
  logic        cfg_ignore_de = 0, cfg_decimate = 0, cfg_keep_second = 0;
  logic        sen_clk = 0;
  logic [7:0]  sen_data = 0;
  logic        sen_de_a = 0, sen_de_b = 0;
  logic        word_valid, word_ready = 0, overrun;
  logic [31:0] word_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  par_capture u_par_capture (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_size(cfg_size),
    .cfg_ignore_de(cfg_ignore_de), .cfg_decimate(cfg_decimate),
    .cfg_keep_second(cfg_keep_second), .sen_clk(sen_clk), .sen_data(sen_data),
    .sen_de_a(sen_de_a), .sen_de_b(sen_de_b), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .overrun(overrun));

  typedef struct packed {
    logic [1:0]  sz;
    logic        ign, dec, k2;
    logic [3:0]  n;
    logic [7:0]  mask;
    logic [7:0]  base;
    logic [31:0] exp;
  } vec_t;

  // mask bit i = both qualifiers high for byte i; byte i value = base + i
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 4'd2, 8'b0000_0010, 8'h10, 32'h0000_0011}, // R2
    '{2'd1, 1'b0, 1'b0, 1'b0, 4'd3, 8'b0000_0101, 8'h20, 32'h0000_2220}, // R2 R5
    '{2'd2, 1'b1, 1'b0, 1'b0, 4'd4, 8'b0000_0000, 8'h30, 32'h3332_3130}, // R3 R5
    '{2'd1, 1'b1, 1'b1, 1'b0, 4'd4, 8'b0000_0000, 8'h40, 32'h0000_4240}, // R4
    '{2'd1, 1'b1, 1'b1, 1'b1, 4'd4, 8'b0000_0000, 8'h50, 32'h0000_5351}, // R4
    '{2'd2, 1'b0, 1'b1, 1'b0, 4'd8, 8'b1111_1111, 8'h60, 32'h6664_6260}, // R4 R5
    '{2'd0, 1'b0, 1'b1, 1'b1, 4'd3, 8'b0000_0110, 8'h70, 32'h0000_0072}, // R2 R4
    '{2'd3, 1'b1, 1'b0, 1'b0, 4'd4, 8'b0000_0000, 8'h80, 32'h8382_8180}  // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sen_edge(input logic [7:0] d, input logic a, input logic b);
    sen_data = d; sen_de_a = a; sen_de_b = b;
    #20 sen_clk = 1;
    #20 sen_clk = 0;
  endtask

  task automatic idle_edges(input int k);
    for (int i = 0; i < k; i++) sen_edge(8'h00, 1'b0, 1'b0);
  endtask

  task automatic start(input logic [1:0] sz, input logic ign, input logic dec,
                       input logic k2);
    cfg_size = sz; cfg_ignore_de = ign; cfg_decimate = dec; cfg_keep_second = k2;
    cfg_enable = 1;
    idle_edges(2);
  endtask

  task automatic stop();
    cfg_enable = 0; cfg_ignore_de = 0; cfg_decimate = 0;
    idle_edges(3);
    repeat (6) @(negedge clk);
  endtask

  task automatic take_word(input string req, input logic [31:0] exp);
    int t = 0;
    while (!word_valid && t < 60) begin @(negedge clk); t++; end
    chk(word_valid === 1'b1, req, 32'(word_valid), 32'd1);
    chk(word_data === exp, req, word_data, exp);
    word_ready = 1;
    @(posedge clk); #1 word_ready = 0;
    @(negedge clk);
  endtask

  task automatic expect_none(input string req);
    repeat (4) @(negedge clk);
    chk(word_valid === 1'b0, req, 32'(word_valid), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(word_valid === 1'b0, "R1", 32'(word_valid), 0);
    chk(overrun === 1'b0, "R1", 32'(overrun), 0);
    chk(word_data === 32'h0, "R1", word_data, 0);

    // table of modes
    for (int v = 0; v < 8; v++) begin
      start(VECS[v].sz, VECS[v].ign, VECS[v].dec, VECS[v].k2);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        logic both;
        both = VECS[v].mask[i];
        sen_edge(VECS[v].base + 8'(i), both | (i % 2 == 0), both | (i % 2 == 1));
      end
      stop();
      take_word($sformatf("R2-R5 vector %0d", v), VECS[v].exp);
      expect_none($sformatf("R5 vector %0d extra word", v));
    end

    // R9: partial word discarded by disable
    start(2'd2, 1'b1, 1'b0, 1'b0);
    sen_edge(8'hAA, 0, 0); sen_edge(8'hAB, 0, 0);
    stop();
    start(2'd2, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) sen_edge(8'hC0 + 8'(i), 0, 0);
    stop();
    // R6: stalled word holds
    repeat (3) @(negedge clk);
    held = word_data;
    repeat (5) @(negedge clk);
    chk(word_valid === 1'b1, "R6 valid held", 32'(word_valid), 1);
    chk(word_data === held, "R6 data held", word_data, held);
    take_word("R9 partial word", 32'hC3C2_C1C0);

    // R9: decimation phase reset by disable
    start(2'd0, 1'b1, 1'b1, 1'b1);
    sen_edge(8'hD0, 0, 0);
    stop();
    start(2'd0, 1'b1, 1'b1, 1'b1);
    sen_edge(8'hE0, 0, 0); sen_edge(8'hE1, 0, 0);
    stop();
    take_word("R9 phase reset", 32'h0000_00E1);
    expect_none("R9 no extra word");

    // R10: disabled capture
    cfg_enable = 0; cfg_ignore_de = 1; cfg_size = 0;
    for (int i = 0; i < 8; i++) sen_edge(8'h90 + 8'(i), 1, 1);
    cfg_ignore_de = 0;
    expect_none("R10 disabled");

    // R7 R8: stall, fill, overflow, then drain back-to-back
    start(2'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) sen_edge(8'hF0 + 8'(i), 1, 1);
    stop();
    chk(overrun === 1'b1, "R8 overrun set", 32'(overrun), 1);
    chk(word_valid === 1'b1, "R7 valid", 32'(word_valid), 1);
    chk(word_data === 32'hF0, "R7 first word", word_data, 32'hF0);
    word_ready = 1;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      chk(word_valid === 1'b1 && word_data === 32'hF0 + 32'(k), "R7 back-to-back",
          word_data, 32'hF0 + 32'(k));
      if (k == 1) chk(overrun === 1'b0, "R8 overrun cleared", 32'(overrun), 0);
    end
    @(negedge clk);
    chk(word_valid === 1'b0, "R8 sixth word dropped", 32'(word_valid), 0);
    word_ready = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule